// File: doc/BRIEF.md
# Set/Clear GPIO Port

This block is a general-purpose I/O port with 32 pins by default, controlled through a small memory-mapped register window. Software never performs a read-modify-write on a shared data register. A write to the set register drives the pins selected by its mask high, and a write to the clear register drives them low. Both writes also turn on the output driver of every selected pin. A separate write releases the selected pins back to input. Mask bits that are 0 leave their pins as they were, so more than one agent can own different pins without any locking.

Each pin has an output latch, an output-enable flag and an input path through a two-flop synchronizer. The synchronized levels are read back through the pin-state register, gated by a per-pin input-enable mask. The raw synchronized levels also leave the block on their own port, for an external interrupt controller. Reads are combinational: read data follows the address in the same cycle. Writes take effect at the next rising clock edge.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset, every output enable and every output latch bit is 0, and every input-enable bit is 1.
- R2: A write to offset 0x108 sets to 1 the output latch bit and the output-enable bit of every pin whose mask bit is 1.
- R3: A write to offset 0x10C clears the output latch bit and sets the output-enable bit of every pin whose mask bit is 1.
- R4: A write to offset 0x100 clears the output-enable bit of every pin whose mask bit is 1 and leaves all output latch bits unchanged.
- R5: Mask bits that are 0 in a write to 0x100, 0x108 or 0x10C leave the latch and enable of that pin unchanged.
- R6: A read of 0x100 returns the output-enable bits, where 1 means the pin is driving. A read of 0x108 returns the output latch. Both are returned in the same cycle as the address.
- R7: A read of 0x110 returns the synchronized pin levels ANDed with the input-enable mask. A change on a pin is visible after two rising clock edges.
- R8: A write to 0x110 loads the input-enable mask. Pins whose enable bit is 0 read as 0 at 0x110.
- R9: The raw synchronized pin levels appear on pin_level_o two rising edges after a pin changes, independent of the input-enable mask.
- R10: A read of any other offset returns 0, and a write to any other offset changes no state.
- R11: pin_o equals the output latch and pin_oe_o equals the output-enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the current address |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data or mask |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pin_i | input | 32 | Pad input levels (asynchronous) |
| pin_o | output | 32 | Pad output levels |
| pin_oe_o | output | 32 | Pad output enables |
| pin_level_o | output | 32 | Raw synchronized pin levels |

## Verification
The hardest case is mixing the three kinds of mask write on overlapping pins. A clear must turn on a driver that is already on without touching the latch of other pins. A tristate write must then release some of those drivers while the latch keeps its value for a later return to output mode. The vector table chains set, clear and tristate writes whose masks overlap, and reads back both the latch and the enables after each write. Further directed steps move pin_i away from the clock edge and sample at each of the next two edges to show the synchronizer latency.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_SET  = 3'd2,
    SEL_CLR  = 3'd3,
    SEL_PIN  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_setclr_decode.sv
module gpio_setclr_decode
  import gpio_setclr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int OFS_DIR = 'h100,
  parameter int OFS_SET = 'h108,
  parameter int OFS_CLR = 'h10C,
  parameter int OFS_PIN = 'h110
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    if      (addr_i == ADDR_W'(OFS_DIR)) sel_o = SEL_DIR;
    else if (addr_i == ADDR_W'(OFS_SET)) sel_o = SEL_SET;
    else if (addr_i == ADDR_W'(OFS_CLR)) sel_o = SEL_CLR;
    else if (addr_i == ADDR_W'(OFS_PIN)) sel_o = SEL_PIN;
    else                                 sel_o = SEL_NONE;
  end
endmodule

// File: rtl/gpio_setclr_sync.sv
module gpio_setclr_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_setclr_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  reg_sel_e            sel_i,
  input  logic [NUM_PINS-1:0] mask_i,
  output logic [NUM_PINS-1:0] latch_o,
  output logic [NUM_PINS-1:0] oe_o,
  output logic [NUM_PINS-1:0] inen_o
);
  logic [NUM_PINS-1:0] latch_q, oe_q, inen_q;
  logic [NUM_PINS-1:0] latch_d, oe_d, inen_d;

  always_comb begin
    latch_d = latch_q;
    oe_d    = oe_q;
    inen_d  = inen_q;
    if (we_i) begin
      unique case (sel_i)
        SEL_SET: begin
          latch_d = latch_q | mask_i;
          oe_d    = oe_q | mask_i;
        end
        SEL_CLR: begin
          latch_d = latch_q & ~mask_i;
          oe_d    = oe_q | mask_i;
        end
        SEL_DIR: oe_d   = oe_q & ~mask_i;
        SEL_PIN: inen_d = mask_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      oe_q    <= '0;
      inen_q  <= '1;
    end else begin
      latch_q <= latch_d;
      oe_q    <= oe_d;
      inen_q  <= inen_d;
    end
  end

  assign latch_o = latch_q;
  assign oe_o    = oe_q;
  assign inen_o  = inen_q;
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_setclr_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int OFS_DIR     = 'h100,
  parameter int OFS_SET     = 'h108,
  parameter int OFS_CLR     = 'h10C,
  parameter int OFS_PIN     = 'h110
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_level_o
);
  reg_sel_e            sel;
  logic [NUM_PINS-1:0] latch, oe, inen, level;

  gpio_setclr_decode #(
    .ADDR_W (ADDR_W),
    .OFS_DIR(OFS_DIR),
    .OFS_SET(OFS_SET),
    .OFS_CLR(OFS_CLR),
    .OFS_PIN(OFS_PIN)
  ) u_decode (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  gpio_setclr_bank #(.NUM_PINS(NUM_PINS)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .sel_i  (sel),
    .mask_i (wdata_i),
    .latch_o(latch),
    .oe_o   (oe),
    .inen_o (inen)
  );

  gpio_setclr_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (level)
  );

  always_comb begin
    unique case (sel)
      SEL_DIR: rdata_o = oe;
      SEL_SET: rdata_o = latch;
      SEL_PIN: rdata_o = level & inen;
      default: rdata_o = '0;
    endcase
  end

  assign pin_o       = latch;
  assign pin_oe_o    = oe;
  assign pin_level_o = level;
endmodule

// File: rtl/gpio_setclr_port_chk.sv
module gpio_setclr_port_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 12,
  parameter int OFS_DIR  = 'h100,
  parameter int OFS_SET  = 'h108,
  parameter int OFS_CLR  = 'h10C,
  parameter int OFS_PIN  = 'h110
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] rdata_o,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o
);
  logic unmapped;
  assign unmapped = addr_i != ADDR_W'(OFS_DIR) && addr_i != ADDR_W'(OFS_SET) &&
                    addr_i != ADDR_W'(OFS_CLR) && addr_i != ADDR_W'(OFS_PIN);

  // R2
  set_drives_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == ADDR_W'(OFS_SET) |=>
      ((pin_o & $past(wdata_i)) == $past(wdata_i)) &&
      ((pin_oe_o & $past(wdata_i)) == $past(wdata_i)));

  // R3
  clr_drives_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == ADDR_W'(OFS_CLR) |=>
      ((pin_o & $past(wdata_i)) == '0) &&
      ((pin_oe_o & $past(wdata_i)) == $past(wdata_i)));

  // R4
  dir_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == ADDR_W'(OFS_DIR) |=>
      ((pin_oe_o & $past(wdata_i)) == '0) && $stable(pin_o));

  // R5
  zero_mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (addr_i == ADDR_W'(OFS_SET) || addr_i == ADDR_W'(OFS_CLR) ||
             addr_i == ADDR_W'(OFS_DIR)) |=>
      ((pin_o & ~$past(wdata_i)) == ($past(pin_o) & ~$past(wdata_i))) &&
      ((pin_oe_o & ~$past(wdata_i)) == ($past(pin_oe_o) & ~$past(wdata_i))));

  // R10
  unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && unmapped |=> $stable(pin_o) && $stable(pin_oe_o));

  // R10
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped |-> rdata_o == '0);

  // R6
  latch_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(OFS_SET) |-> rdata_o == pin_o);
endmodule

bind gpio_setclr_port gpio_setclr_port_chk #(
  .NUM_PINS(NUM_PINS),
  .ADDR_W  (ADDR_W),
  .OFS_DIR (OFS_DIR),
  .OFS_SET (OFS_SET),
  .OFS_CLR (OFS_CLR),
  .OFS_PIN (OFS_PIN)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o)
);

// File: tb/tb_gpio_setclr_port.sv
module tb_gpio_setclr_port;
  localparam int NP = 32;
  localparam int AW = 12;
  localparam logic [NP-1:0] PIN_A = 32'hA5A5_0F0F;
  localparam logic [NP-1:0] PIN_B = 32'h5A5A_F0F0;

  logic clk_i = 1'b0, rst_ni = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [NP-1:0] wdata_i = '0, pin_i = PIN_A;
  logic [NP-1:0] rdata_o, pin_o, pin_oe_o, pin_level_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_setclr_port dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .pin_level_o(pin_level_o)
  );

  // {is_read, req number, addr, data or expected}
  localparam int NV = 22;
  localparam logic [52:0] VEC [NV] = '{
    {1'b1, 8'd1,  12'h100, 32'h0000_0000},  // R1 enables off
    {1'b1, 8'd1,  12'h108, 32'h0000_0000},  // R1 latch zero
    {1'b1, 8'd7,  12'h110, 32'hA5A5_0F0F},  // R7 live levels
    {1'b0, 8'd2,  12'h108, 32'h0000_00F0},  // R2 set
    {1'b1, 8'd6,  12'h108, 32'h0000_00F0},  // R6 latch
    {1'b1, 8'd2,  12'h100, 32'h0000_00F0},  // R2 enables on
    {1'b0, 8'd3,  12'h10C, 32'h0000_0303},  // R3 clear, overlaps nothing set
    {1'b1, 8'd5,  12'h108, 32'h0000_00F0},  // R5 latch kept
    {1'b1, 8'd3,  12'h100, 32'h0000_03F3},  // R3 clear turns drivers on
    {1'b0, 8'd3,  12'h10C, 32'h0000_0030},  // R3 clear overlapping set pins
    {1'b1, 8'd3,  12'h108, 32'h0000_00C0},  // R3
    {1'b0, 8'd4,  12'h100, 32'h0000_00F0},  // R4 release
    {1'b1, 8'd4,  12'h100, 32'h0000_0303},  // R4
    {1'b1, 8'd4,  12'h108, 32'h0000_00C0},  // R4 latch untouched
    {1'b0, 8'd10, 12'h104, 32'hFFFF_FFFF},  // R10 unmapped write
    {1'b1, 8'd10, 12'h104, 32'h0000_0000},  // R10 unmapped read
    {1'b1, 8'd10, 12'h100, 32'h0000_0303},  // R10 no state change
    {1'b1, 8'd10, 12'h108, 32'h0000_00C0},  // R10
    {1'b0, 8'd8,  12'h110, 32'h0000_FFFF},  // R8 input enable
    {1'b1, 8'd8,  12'h110, 32'h0000_0F0F},  // R8 gated
    {1'b0, 8'd2,  12'h108, 32'h8000_0000},  // R2 top pin
    {1'b1, 8'd6,  12'h100, 32'h8000_0303}   // R6
  };

  task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NP-1:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [NP-1:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #1 check(req, rdata_o, exp);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk_i);
        if (!done) begin
          n_bad++; n_chk++;
          $display("FAIL watchdog act=hung exp=done");
          $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][52]) rd($sformatf("R%0d vec%0d", VEC[i][51:44], i), VEC[i][43:32], VEC[i][31:0]);
      else            wr(VEC[i][43:32], VEC[i][31:0]);
    end

    // R11 pad outputs mirror latch and enables
    @(negedge clk_i);
    check("R11 pin_o", pin_o, 32'h8000_00C0);
    check("R11 pin_oe_o", pin_oe_o, 32'h8000_0303);
    // R9 raw level ignores input-enable
    check("R9 raw", pin_level_o, PIN_A);

    // R7/R9 two-edge latency
    @(negedge clk_i);
    pin_i = PIN_B;
    addr_i = 12'h110;
    @(negedge clk_i);
    check("R9 after 1 edge", pin_level_o, PIN_A);
    @(negedge clk_i);
    check("R9 after 2 edges", pin_level_o, PIN_B);
    check("R7 gated after 2 edges", rdata_o, PIN_B & 32'h0000_FFFF);

    // R1 reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check("R1 pin_oe_o", pin_oe_o, '0);
    check("R1 pin_o", pin_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    rd("R1 input enable all ones", 12'h110, PIN_B);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule